// File: doc/BRIEF.md
# Alarm Match Unit

This block holds a four-field alarm (seconds, minutes, hours, day of month), each field stored as one BCD byte whose top bit is a repeat mask. Once per second a timekeeper pulses a one-cycle strobe and presents the current BCD time. On that strobe cycle the block compares the unmasked alarm fields with the time. When they agree, it raises a one-cycle interrupt pulse.

The combination of mask bits sets the repeat rate. With no masks the alarm fires once a month. A masked day gives a daily alarm. Masked day and hour give an hourly alarm. Masked day, hour and minute give an alarm every minute. Every other combination fires on every strobe. Software programs the alarm through a byte-wide register port. A write whose BCD value is out of range for its field is dropped, and the register keeps its old contents. An interrupt-enable byte sits in the same register space. It is stored and can be read back, but it has no effect on the interrupt.

The interrupt is produced by a two-state machine. ST_IDLE is the reset state and the resting state. The transition "strobe with match" moves ST_IDLE to ST_PULSE. ST_PULSE drives the interrupt high for one cycle. It then takes the transition "pulse done" back to ST_IDLE, or "strobe with match" again if another matching strobe arrives in that cycle.

Top module: `alm_match_unit`

## Requirements
- R1: Register addresses are: 0 alarm seconds, 1 alarm minutes, 2 alarm hours, 3 alarm day, 4 interrupt enable. A read of one of these addresses returns the stored byte, including bit 7. A read of any other address returns 0, and a write to any other address changes nothing.
- R2: With bits 7 of all four alarm bytes clear, a strobe produces a pulse only when all four fields match. The fields are seconds bits 6:0, minutes bits 6:0, hours bits 5:0 and day bits 5:0, each compared with the same bits of the current time.
- R3: With only the day mask set, a match needs hours, minutes and seconds. With the day and hour masks set, it needs minutes and seconds. With the day, hour and minute masks set, it needs seconds only.
- R4: Any other mask combination, including all four masks set, gives a pulse on every strobe.
- R5: A write to alarm seconds or minutes is kept only if bits 6:0 are within 0 to 59. The value is (bits 6:4)*10 + (bits 3:0). Otherwise the register is unchanged.
- R6: A write to alarm hours is kept only if (bits 5:4)*10 + (bits 3:0) is at most 23. A write to alarm day is kept only if bits 5:0 are nonzero.
- R7: A matching strobe at clock edge N raises alarm_irq for exactly the cycle after edge N. Without a matching strobe, alarm_irq stays low.
- R8: The interrupt-enable byte is stored only. Its value does not change alarm_irq.
- R9: After reset, all five registers read 0 and alarm_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
The bench builds the block with the default ADDR_W of 3. This makes the whole address space reachable, so the three unused addresses can be tested alongside the five real ones. All 256 byte values are written to each alarm field, and the kept-or-dropped result is predicted from the BCD arithmetic. This exercises every edge of the range checks, including non-decimal nibbles. All sixteen mask combinations are then each tried against five time patterns, with one field at a time made to disagree. This covers every repeat rate and every fall-through combination.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int NSLOT = 4;
    localparam int SLOT_SEC  = 0;
    localparam int SLOT_MIN  = 1;
    localparam int SLOT_HOUR = 2;
    localparam int SLOT_DATE = 3;
    localparam int ADR_IEN   = NSLOT;

    localparam logic [6:0] LIM_SEC  = 7'd59;
    localparam logic [6:0] LIM_HOUR = 7'd23;

    typedef enum logic [2:0] {
        RATE_MONTH,
        RATE_DAY,
        RATE_HOUR,
        RATE_MINUTE,
        RATE_SECOND
    } rate_e;

    typedef enum logic {
        ST_IDLE,
        ST_PULSE
    } irq_state_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] date;
    } alarm_val_t;

    // Binary value of a two-digit BCD byte (upper digit 3 bits wide)
    function automatic logic [6:0] bcd_val(input logic [6:0] b);
        return ({4'b0, b[6:4]} * 7'd10) + {3'b0, b[3:0]};
    endfunction

endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output alarm_val_t        vals,
    output logic [NSLOT-1:0]  masks
);

    logic [7:0]       slot_q [NSLOT];
    logic [7:0]       ien_q;
    logic [NSLOT-1:0] ok;

    // Per-field range check on the incoming byte
    always_comb begin
        ok[SLOT_SEC]  = bcd_val(wdata[6:0]) <= LIM_SEC;
        ok[SLOT_MIN]  = bcd_val(wdata[6:0]) <= LIM_SEC;
        ok[SLOT_HOUR] = bcd_val({1'b0, wdata[5:0]}) <= LIM_HOUR;
        ok[SLOT_DATE] = wdata[5:0] != 6'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= 8'h00;
            ien_q <= 8'h00;
        end else if (wr) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (addr == ADDR_W'(i) && ok[i]) slot_q[i] <= wdata;
            end
            if (addr == ADDR_W'(ADR_IEN)) ien_q <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NSLOT; i++) begin
            if (addr == ADDR_W'(i)) rdata = slot_q[i];
        end
        if (addr == ADDR_W'(ADR_IEN)) rdata = ien_q;
    end

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_mask
            assign masks[g] = slot_q[g][7];
        end
    endgenerate

    assign vals.sec  = slot_q[SLOT_SEC][6:0];
    assign vals.min  = slot_q[SLOT_MIN][6:0];
    assign vals.hour = slot_q[SLOT_HOUR][5:0];
    assign vals.date = slot_q[SLOT_DATE][5:0];

    assert_sec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(SLOT_SEC) && bcd_val(wdata[6:0]) > LIM_SEC)
        |=> $stable(slot_q[SLOT_SEC]));

    assert_hour_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(SLOT_HOUR) && bcd_val({1'b0, wdata[5:0]}) > LIM_HOUR)
        |=> $stable(slot_q[SLOT_HOUR]));

    assert_date_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(SLOT_DATE) && wdata[5:0] == 6'd0)
        |=> $stable(slot_q[SLOT_DATE]));

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (slot_q[SLOT_SEC] == 8'h00 && slot_q[SLOT_DATE] == 8'h00 && ien_q == 8'h00));

endmodule

// File: rtl/alm_rate.sv
module alm_rate
    import alm_pkg::*;
(
    input  logic [NSLOT-1:0] masks,
    output rate_e            rate
);

    // Mask order: {date, hour, min, sec}
    always_comb begin
        unique case ({masks[SLOT_DATE], masks[SLOT_HOUR], masks[SLOT_MIN], masks[SLOT_SEC]})
            4'b0000: rate = RATE_MONTH;
            4'b1000: rate = RATE_DAY;
            4'b1100: rate = RATE_HOUR;
            4'b1110: rate = RATE_MINUTE;
            default: rate = RATE_SECOND;
        endcase
    end

endmodule

// File: rtl/alm_cmp.sv
module alm_cmp
    import alm_pkg::*;
(
    input  alarm_val_t  vals,
    input  rate_e       rate,
    input  logic [6:0]  now_sec,
    input  logic [6:0]  now_min,
    input  logic [5:0]  now_hour,
    input  logic [5:0]  now_date,
    output logic        hit
);

    logic eq_s, eq_m, eq_h, eq_d;

    always_comb begin
        eq_s = vals.sec  == now_sec;
        eq_m = vals.min  == now_min;
        eq_h = vals.hour == now_hour;
        eq_d = vals.date == now_date;
        unique case (rate)
            RATE_MONTH:  hit = eq_d && eq_h && eq_m && eq_s;
            RATE_DAY:    hit = eq_h && eq_m && eq_s;
            RATE_HOUR:   hit = eq_m && eq_s;
            RATE_MINUTE: hit = eq_s;
            default:     hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/alm_match_unit.sv
module alm_match_unit
    import alm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              sec_tick,
    input  logic [6:0]        now_sec,
    input  logic [6:0]        now_min,
    input  logic [5:0]        now_hour,
    input  logic [5:0]        now_date,
    output logic              alarm_irq
);

    alarm_val_t       vals;
    logic [NSLOT-1:0] masks;
    rate_e            rate;
    logic             hit;
    irq_state_e       state_q, state_d;

    alm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .vals  (vals),
        .masks (masks)
    );

    alm_rate u_rate (
        .masks (masks),
        .rate  (rate)
    );

    alm_cmp u_cmp (
        .vals     (vals),
        .rate     (rate),
        .now_sec  (now_sec),
        .now_min  (now_min),
        .now_hour (now_hour),
        .now_date (now_date),
        .hit      (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = (sec_tick && hit) ? ST_PULSE : ST_IDLE;
            ST_PULSE: state_d = (sec_tick && hit) ? ST_PULSE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        alarm_irq = (state_q == ST_PULSE);
    end

    assert_pulse_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> !alarm_irq);

    assert_pulse_follows_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && hit) |=> alarm_irq);

    assert_all_masked_every_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && masks == '1) |=> alarm_irq);

    assert_monthly_needs_date_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && masks == '0 && now_date != vals.date) |=> !alarm_irq);

endmodule

// File: tb/alm_match_unit_test.sv
module alm_match_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sec_tick = 1'b0;
    logic [6:0] now_sec = '0;
    logic [6:0] now_min = '0;
    logic [5:0] now_hour = '0;
    logic [5:0] now_date = '0;
    logic       alarm_irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    alm_match_unit #(.ADDR_W(3)) uut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .sec_tick (sec_tick),
        .now_sec (now_sec), .now_min (now_min), .now_hour (now_hour),
        .now_date (now_date), .alarm_irq (alarm_irq)
    );

    task automatic check8(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check8(req, reg_rdata, exp);
    endtask

    task automatic tick_chk(string req, logic exp);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        check8(req, {7'd0, alarm_irq}, {7'd0, exp});
        @(negedge clk);
        check8({req, " pulse end R7"}, {7'd0, alarm_irq}, 8'd0);
    endtask

    function automatic int dec(logic [6:0] b);
        return int'(b[6:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic bit field_ok(int f, logic [7:0] d);
        case (f)
            0, 1: return dec(d[6:0]) <= 59;
            2:    return dec({1'b0, d[5:0]}) <= 23;
            default: return d[5:0] != 6'd0;
        endcase
    endfunction

    function automatic bit exp_hit(logic [3:0] m, bit es, bit em, bit eh, bit ed);
        case (m)  // {date,hour,min,sec}
            4'b0000: return ed && eh && em && es;
            4'b1000: return eh && em && es;
            4'b1100: return em && es;
            4'b1110: return es;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        for (int a = 0; a < 5; a++) rd_chk("R9 reset reg", 3'(a), 8'h00);
        check8("R9 reset irq", {7'd0, alarm_irq}, 8'd0);

        // R5/R6: full sweep of every field
        for (int f = 0; f < 4; f++) begin
            held = 8'h00;
            for (int d = 0; d < 256; d++) begin
                wr(3'(f), 8'(d));
                if (field_ok(f, 8'(d))) held = 8'(d);
                rd_chk((f < 2) ? "R5 range" : "R6 range", 3'(f), held);
            end
        end

        // R1: enable byte and unmapped addresses
        wr(3'd4, 8'hA5);
        rd_chk("R1 ien readback", 3'd4, 8'hA5);
        wr(3'd1, 8'h45);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 8'hFF);
            rd_chk("R1 unmapped read", 3'(a), 8'h00);
        end
        rd_chk("R1 min intact", 3'd1, 8'h45);
        rd_chk("R1 ien intact", 3'd4, 8'hA5);

        // R2/R3/R4: all mask combinations, one field disturbed at a time
        for (int m = 0; m < 16; m++) begin
            wr(3'd0, {m[0], 7'h30});
            wr(3'd1, {m[1], 7'h45});
            wr(3'd2, {m[2], 7'h12});
            wr(3'd3, {m[3], 7'h15});
            for (int p = 0; p < 5; p++) begin
                @(negedge clk);
                now_sec  = (p == 1) ? 7'h31 : 7'h30;
                now_min  = (p == 2) ? 7'h46 : 7'h45;
                now_hour = (p == 3) ? 6'h13 : 6'h12;
                now_date = (p == 4) ? 6'h16 : 6'h15;
                tick_chk((m == 0) ? "R2 monthly" :
                         (m == 8 || m == 12 || m == 14) ? "R3 rate" : "R4 every second",
                         exp_hit(4'(m), p != 1, p != 2, p != 3, p != 4));
            end
        end

        // R7: matching time but no strobe gives no pulse
        wr(3'd0, 8'h30); wr(3'd1, 8'h45); wr(3'd2, 8'h12); wr(3'd3, 8'h15);
        @(negedge clk);
        now_sec = 7'h30; now_min = 7'h45; now_hour = 6'h12; now_date = 6'h15;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check8("R7 no strobe", {7'd0, alarm_irq}, 8'd0);
        end

        // R8: enable byte value has no effect
        wr(3'd4, 8'h00);
        tick_chk("R8 ien zero", 1'b1);
        wr(3'd4, 8'hFF);
        tick_chk("R8 ien ones", 1'b1);
        @(negedge clk);
        now_sec = 7'h59;
        tick_chk("R8 ien ones miss", 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule